// File: doc/BRIEF.md
# String Operation Repeat Controller

This block sequences one repeated string operation: move, compare, scan, load or store. A caller pulses `start` with the starting source offset, destination offset and count. It also gives the direction flag, a byte/word select, the repeat kind and the operation class. For each element the block raises a source strobe, a destination strobe or both, together with the current offsets. An external data path answers with `xfer_ack`, and the zero flag of that element arrives with the acknowledge.

After each acknowledge the block steps the offsets and decrements the count. It then pulses `elem_done`. It stops when the count runs out or when the zero-flag condition of the repeat kind fails. On stopping it pulses `op_done`, and the final offsets and count are valid on `si_out`, `di_out` and `cx_out` in that same cycle.

A separate combinational port group evaluates the three counted-loop branch conditions.

Top module: `strrep_ctrl`

## Requirements
- R1: After reset the block is idle. `busy`, both strobes, `elem_done` and `op_done` are 0, and the offset and count outputs are 0. An `xfer_ack` while no strobe is raised has no effect.
- R2: The strobes depend on `op_in` (0 move, 1 compare, 2 scan, 3 load, 4 store). Move and compare raise both strobes. Scan and store raise only `dst_req`. Load raises only `src_req`. `src_off` and `dst_off` carry the current source and destination offsets.
- R3: After each acknowledged element, an offset whose strobe was raised steps by 1 when `word_in`=0 and by 2 when `word_in`=1. It increases when `dir_in`=0 and decreases when `dir_in`=1, wrapping modulo 2^16. An offset whose strobe was not raised keeps its value.
- R4: With `rep_in`=1 (unconditional repeat), the count drops by one for each element, and the run stops after the element that brings it to 0.
- R5: With `rep_in`=2 (repeat while equal) or 3 (repeat while not equal), and a compare or scan operation, the count is first decremented. The run then also stops when `zf_in` at the acknowledge is 0 (for 2) or 1 (for 3).
- R6: For move, load and store, `zf_in` is ignored, and repeat kinds 2 and 3 behave like kind 1.
- R7: If `rep_in` is nonzero and `cx_in` is 0 at start, no strobe is raised and no `elem_done` occurs. `op_done` pulses one cycle after start, with the three outputs equal to the start values.
- R8: With `rep_in`=0, exactly one element is processed and the count output stays equal to `cx_in`.
- R9: `elem_done` pulses in the cycle after each acknowledge. `op_done` is a one-cycle pulse that coincides with the last `elem_done`, and `busy` is 0 in that cycle.
- R10: `start` is ignored while `busy` is 1.
- R11: Loop evaluation is combinational. `loop_cx_out` = `loop_cx_in` − 1 modulo 2^16. `loop_taken` is 1 when that value is nonzero and the condition of `loop_kind` holds: 0 always, 1 needs `loop_zf`=1, 2 needs `loop_zf`=0. Kind 3 is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| rep_in | input | 2 | Repeat kind: 0 none, 1 unconditional, 2 while equal, 3 while not equal |
| op_in | input | 3 | Operation class: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| dir_in | input | 1 | 0 step up, 1 step down |
| word_in | input | 1 | 0 byte elements, 1 word elements |
| si_in | input | 16 | Starting source offset |
| di_in | input | 16 | Starting destination offset |
| cx_in | input | 16 | Starting count |
| xfer_ack | input | 1 | Data path has finished the current element |
| zf_in | input | 1 | Zero flag of the acknowledged element |
| busy | output | 1 | Operation in progress |
| src_req | output | 1 | Source access strobe |
| dst_req | output | 1 | Destination access strobe |
| src_off | output | 16 | Source offset for the current element |
| dst_off | output | 16 | Destination offset for the current element |
| elem_done | output | 1 | One element finished |
| op_done | output | 1 | Operation finished |
| si_out | output | 16 | Current or final source offset |
| di_out | output | 16 | Current or final destination offset |
| cx_out | output | 16 | Current or final count |
| loop_kind | input | 2 | Loop kind: 0 plain, 1 while equal, 2 while not equal |
| loop_cx_in | input | 16 | Count before the loop instruction |
| loop_zf | input | 1 | Zero flag for the loop condition |
| loop_cx_out | output | 16 | Decremented count |
| loop_taken | output | 1 | Branch condition met |

## Verification
The hardest situation to reach is an early stop in the middle of a conditional run. That stop needs a compare or scan operation, a count still above zero, and a zero flag that flips on one exact element. The stimulus fixes that by passing a per-element zero-flag vector, so the acknowledge for element k carries bit k. Wrap-around needs offsets placed at 0x0000 or 0xFFFF so that one step crosses the boundary. Proving that `start` is ignored during a run means holding `start` high with different values for the whole run. The reference model predicts strobes, offsets, count and pulses on every cycle and is compared against the ports.

// File: rtl/strrep_pkg.sv
package strrep_pkg;
    typedef enum logic [1:0] {REP_NONE, REP_ALL, REP_EQ, REP_NE} rep_kind_e;
    typedef enum logic [2:0] {OP_MOVE, OP_CMP, OP_SCAN, OP_LOAD, OP_STORE} op_class_e;
    typedef enum logic [1:0] {LP_PLAIN, LP_EQ, LP_NE} loop_kind_e;
    typedef enum logic {ST_IDLE, ST_XFER} state_e;
endpackage

// File: rtl/strrep_stepper.sv
module strrep_stepper #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic          en,
    input  logic          down,
    input  logic          word,
    output logic [AW-1:0] next
);
    logic [AW-1:0] step;
    always_comb begin
        step = word ? AW'(2) : AW'(1);
        if (!en)
            next = base;
        else if (down)
            next = base - step;
        else
            next = base + step;
    end
endmodule

// File: rtl/strrep_term.sv
module strrep_term #(
    parameter int AW = 16
) (
    input  strrep_pkg::rep_kind_e rep,
    input  strrep_pkg::op_class_e op,
    input  logic [AW-1:0]         cx_new,
    input  logic                  zf,
    output logic                  stop
);
    import strrep_pkg::*;
    logic zf_used;
    logic cx_zero;
    always_comb begin
        zf_used = (op == OP_CMP) || (op == OP_SCAN);
        cx_zero = (cx_new == '0);
        unique case (rep)
            REP_NONE: stop = 1'b1;
            REP_ALL:  stop = cx_zero;
            REP_EQ:   stop = cx_zero || (zf_used && !zf);
            REP_NE:   stop = cx_zero || (zf_used && zf);
            default:  stop = 1'b1;
        endcase
    end
endmodule

// File: rtl/strrep_loop_eval.sv
module strrep_loop_eval #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cx_in,
    input  logic [1:0]    kind,
    input  logic          zf,
    output logic [AW-1:0] cx_next,
    output logic          taken
);
    import strrep_pkg::*;
    logic cond;
    always_comb begin
        cx_next = cx_in - AW'(1);
        unique case (kind)
            LP_PLAIN: cond = 1'b1;
            LP_EQ:    cond = zf;
            LP_NE:    cond = !zf;
            default:  cond = 1'b0;
        endcase
        taken = cond && (cx_next != '0);
    end
endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    rep_in,
    input  logic [2:0]    op_in,
    input  logic          dir_in,
    input  logic          word_in,
    input  logic [AW-1:0] si_in,
    input  logic [AW-1:0] di_in,
    input  logic [AW-1:0] cx_in,
    input  logic          xfer_ack,
    input  logic          zf_in,
    output logic          busy,
    output logic          src_req,
    output logic          dst_req,
    output logic [AW-1:0] src_off,
    output logic [AW-1:0] dst_off,
    output logic          elem_done,
    output logic          op_done,
    output logic [AW-1:0] si_out,
    output logic [AW-1:0] di_out,
    output logic [AW-1:0] cx_out,
    input  logic [1:0]    loop_kind,
    input  logic [AW-1:0] loop_cx_in,
    input  logic          loop_zf,
    output logic [AW-1:0] loop_cx_out,
    output logic          loop_taken
);
    import strrep_pkg::*;

    typedef struct packed {
        state_e        st;
        rep_kind_e     rep;
        op_class_e     op;
        logic          dir;
        logic          word;
        logic [AW-1:0] si;
        logic [AW-1:0] di;
        logic [AW-1:0] cx;
        logic          elem_done;
        logic          op_done;
    } ctrl_t;

    ctrl_t         q, d;
    logic          uses_src, uses_dst;
    logic [AW-1:0] si_nx, di_nx, cx_nx;
    logic          stop;

    // Access pattern of each operation class; unknown codes act as move
    always_comb begin
        unique case (q.op)
            OP_SCAN, OP_STORE: begin uses_src = 1'b0; uses_dst = 1'b1; end
            OP_LOAD:           begin uses_src = 1'b1; uses_dst = 1'b0; end
            default:           begin uses_src = 1'b1; uses_dst = 1'b1; end
        endcase
    end

    strrep_stepper #(.AW(AW)) u_si_step (
        .base(q.si), .en(uses_src), .down(q.dir), .word(q.word), .next(si_nx)
    );
    strrep_stepper #(.AW(AW)) u_di_step (
        .base(q.di), .en(uses_dst), .down(q.dir), .word(q.word), .next(di_nx)
    );

    assign cx_nx = (q.rep == REP_NONE) ? q.cx : q.cx - AW'(1);

    strrep_term #(.AW(AW)) u_term (
        .rep(q.rep), .op(q.op), .cx_new(cx_nx), .zf(zf_in), .stop(stop)
    );

    strrep_loop_eval #(.AW(AW)) u_loop (
        .cx_in(loop_cx_in), .kind(loop_kind), .zf(loop_zf),
        .cx_next(loop_cx_out), .taken(loop_taken)
    );

    always_comb begin
        d           = q;
        d.elem_done = 1'b0;
        d.op_done   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.rep  = rep_kind_e'(rep_in);
                    d.op   = op_class_e'(op_in);
                    d.dir  = dir_in;
                    d.word = word_in;
                    d.si   = si_in;
                    d.di   = di_in;
                    d.cx   = cx_in;
                    if (rep_in != 2'd0 && cx_in == '0)
                        d.op_done = 1'b1;
                    else
                        d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_ack) begin
                    d.si        = si_nx;
                    d.di        = di_nx;
                    d.cx        = cx_nx;
                    d.elem_done = 1'b1;
                    if (stop) begin
                        d.op_done = 1'b1;
                        d.st      = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rep: REP_NONE, op: OP_MOVE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st == ST_XFER);
    assign src_req   = busy && uses_src;
    assign dst_req   = busy && uses_dst;
    assign src_off   = q.si;
    assign dst_off   = q.di;
    assign elem_done = q.elem_done;
    assign op_done   = q.op_done;
    assign si_out    = q.si;
    assign di_out    = q.di;
    assign cx_out    = q.cx;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_req && !dst_req));
    a_r3_src_up_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && src_req && !q.dir && !q.word) |=> (si_out == $past(si_out) + AW'(1)));
    a_r3_dst_down_word: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && dst_req && q.dir && q.word) |=> (di_out == $past(di_out) - AW'(2)));
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_ack && q.rep != REP_NONE) |=> (cx_out == $past(cx_out) - AW'(1)));
    a_r4_last_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_ack && q.rep == REP_ALL && cx_out == AW'(1)) |=> (op_done && !busy));
    a_r8_single_elem: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_ack && q.rep == REP_NONE) |=> (op_done && cx_out == $past(cx_out)));
    a_r9_elem_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        elem_done |-> $past(busy && xfer_ack));
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !busy);
    a_r11_taken_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        loop_taken |-> (loop_cx_out != '0));
endmodule

// File: tb/tb_strrep_ctrl.sv
module tb_strrep_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  rep_in = '0;
    logic [2:0]  op_in = '0;
    logic        dir_in = 1'b0, word_in = 1'b0;
    logic [15:0] si_in = '0, di_in = '0, cx_in = '0;
    logic        xfer_ack = 1'b0, zf_in = 1'b0;
    logic        busy, src_req, dst_req, elem_done, op_done;
    logic [15:0] src_off, dst_off, si_out, di_out, cx_out;
    logic [1:0]  loop_kind = '0;
    logic [15:0] loop_cx_in = '0;
    logic        loop_zf = 1'b0;
    logic [15:0] loop_cx_out;
    logic        loop_taken;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    strrep_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rep_in(rep_in), .op_in(op_in),
        .dir_in(dir_in), .word_in(word_in), .si_in(si_in), .di_in(di_in), .cx_in(cx_in),
        .xfer_ack(xfer_ack), .zf_in(zf_in), .busy(busy), .src_req(src_req),
        .dst_req(dst_req), .src_off(src_off), .dst_off(dst_off), .elem_done(elem_done),
        .op_done(op_done), .si_out(si_out), .di_out(di_out), .cx_out(cx_out),
        .loop_kind(loop_kind), .loop_cx_in(loop_cx_in), .loop_zf(loop_zf),
        .loop_cx_out(loop_cx_out), .loop_taken(loop_taken)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model run; op: 0 move 1 cmp 2 scan 3 load 4 store
    task automatic run(input int op, input int rep, input bit dir, input bit w,
                       input logic [15:0] si, input logic [15:0] di,
                       input logic [15:0] cx, input logic [15:0] zfb, input bit junk);
        logic [15:0] m_si = si, m_di = di, m_cx = cx;
        bit us = (op == 0 || op == 1 || op == 3);
        bit ud = (op != 3);
        bit zu = (op == 1 || op == 2);
        logic [15:0] st = w ? 16'd2 : 16'd1;
        bit stop = 1'b0;
        @(negedge clk);
        op_in = 3'(op); rep_in = 2'(rep); dir_in = dir; word_in = w;
        si_in = si; di_in = di; cx_in = cx; start = 1'b1;
        @(negedge clk);
        if (junk) begin
            si_in = 16'h1234; di_in = 16'h5678; cx_in = 16'h0009; rep_in = 2'd0;
        end else start = 1'b0;
        if (rep != 0 && cx == 0) begin
            chk(op_done && !elem_done && !busy && !src_req && !dst_req,
                "R7 empty run pulses", {op_done, elem_done, busy}, 3'b100);
            chk(si_out == si && di_out == di && cx_out == 0, "R7 regs kept", si_out, si);
            start = 1'b0;
            @(negedge clk);
            chk(!op_done, "R9 done one cycle", op_done, 0);
            return;
        end
        chk(!elem_done && !op_done, "R9 no pulse before ack", elem_done, 0);
        for (int e = 0; e < 40 && !stop; e++) begin
            chk(busy && src_req == us && dst_req == ud, "R2 strobes", {busy, src_req, dst_req}, {1'b1, us, ud});
            if (us) chk(src_off == m_si, "R2 src offset", src_off, m_si);
            if (ud) chk(dst_off == m_di, "R2 dst offset", dst_off, m_di);
            for (int k = 0; k < (e % 3); k++) begin
                @(negedge clk);
                chk(busy && !elem_done && src_req == us, "R9 hold while waiting", elem_done, 0);
            end
            xfer_ack = 1'b1; zf_in = zfb[e];
            if (us) m_si = dir ? m_si - st : m_si + st;
            if (ud) m_di = dir ? m_di - st : m_di + st;
            if (rep != 0) m_cx = m_cx - 16'd1;
            stop = (rep == 0) || (m_cx == 0) ||
                   (zu && rep == 2 && !zfb[e]) || (zu && rep == 3 && zfb[e]);
            @(negedge clk);
            xfer_ack = 1'b0; zf_in = 1'b0;
            chk(elem_done, "R9 elem pulse", elem_done, 1);
            chk(si_out == m_si, "R3 si step", si_out, m_si);
            chk(di_out == m_di, "R3 di step", di_out, m_di);
            chk(cx_out == m_cx, "R4 count", cx_out, m_cx);
            chk(op_done == stop && busy == !stop, "R5 stop decision", {op_done, busy}, {stop, !stop});
        end
        start = 1'b0;
        @(negedge clk);
        chk(!op_done && !busy && !elem_done, "R9 pulses end", {op_done, busy, elem_done}, 0);
    endtask

    task automatic lp(input int kind, input logic [15:0] cx, input bit zf, input bit exp_t);
        loop_kind = 2'(kind); loop_cx_in = cx; loop_zf = zf;
        #1;
        chk(loop_cx_out == cx - 16'd1, "R11 loop count", loop_cx_out, cx - 16'd1);
        chk(loop_taken == exp_t, "R11 loop taken", loop_taken, exp_t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !src_req && !dst_req && !elem_done && !op_done, "R1 idle after reset",
            {busy, src_req, dst_req, elem_done, op_done}, 0);
        chk(si_out == 0 && di_out == 0 && cx_out == 0, "R1 regs zero", cx_out, 0);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk(!elem_done && !op_done && cx_out == 0, "R1 stray ack ignored", elem_done, 0);

        run(0, 1, 0, 1, 16'h0100, 16'h0200, 16'd3, 16'h0000, 0); // R4 word move up
        run(0, 1, 1, 0, 16'h0000, 16'h0001, 16'd3, 16'h0000, 0); // R3 byte down, wrap
        run(1, 2, 0, 0, 16'h0010, 16'h0020, 16'd5, 16'h0003, 0); // R5 stops on 3rd
        run(2, 3, 0, 1, 16'h0000, 16'hFFFF, 16'd4, 16'h0002, 0); // R5 scan, wrap up
        run(1, 3, 1, 1, 16'h0040, 16'h0050, 16'd2, 16'h0000, 0); // R5 runs to count end
        run(4, 2, 0, 0, 16'h0000, 16'h0300, 16'd2, 16'h0000, 0); // R6 store ignores zf
        run(0, 3, 0, 0, 16'h0005, 16'h0006, 16'd3, 16'hFFFF, 0); // R6 move ignores zf
        run(3, 0, 0, 1, 16'h0700, 16'h0800, 16'd7, 16'h0000, 0); // R8 single load
        run(2, 0, 1, 0, 16'h0700, 16'h0800, 16'd0, 16'h0000, 0); // R8 single scan, cx 0
        run(0, 1, 0, 0, 16'h0011, 16'h0022, 16'd0, 16'h0000, 0); // R7 empty
        run(1, 2, 0, 0, 16'h0011, 16'h0022, 16'd0, 16'h0000, 0); // R7 empty compare
        run(0, 1, 0, 1, 16'h0900, 16'h0A00, 16'd4, 16'h0000, 1); // R10 start held busy

        lp(0, 16'd1, 0, 0);      // R11 count reaches 0
        lp(0, 16'd0, 0, 1);      // R11 wrap to FFFF taken
        lp(1, 16'd5, 0, 0);      // R11 equal needs zf 1
        lp(1, 16'd5, 1, 1);
        lp(2, 16'd5, 0, 1);      // R11 not-equal needs zf 0
        lp(2, 16'd5, 1, 0);
        lp(3, 16'd5, 0, 0);      // R11 kind 3 never taken

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule